// File: doc/BRIEF.md
# Three-wire serial configuration register port

This block is a write-only serial slave that fills a bank of four 14-bit configuration registers from three wires: an active-low frame select, a serial data line and a serial shift clock. While the frame select is low, each rising edge of the serial clock shifts one data bit into a 16-bit word, most significant bit first. When the frame select rises, the word is decoded. The leading 14 bits are the payload and the trailing 2 bits pick which of the four registers receives it. The registers drive a flat parallel bus. Downstream logic uses that bus for settings such as operating mode, pin roles, divider ratios and test controls.

All three wires are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are found from the synchronised copies. A frame commits only if exactly 16 bits were shifted. Any other length leaves the bank untouched and raises a one-cycle error pulse. A good commit raises a one-cycle write strobe along with the address that was written.

Top module: `cfg_serial_port`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge every register in `cfg_bus` is zero and `wr_strobe` and `frame_err` are low.
- R2: A frame of exactly 16 bits is shifted in order bit 15 first. Bits 15..2 are the payload and bits 1..0 are the register address. Register k occupies `cfg_bus[14*k+13 : 14*k]`. When `frame_n` rises, that register takes the payload.
- R3: A commit changes only the addressed register. The other three keep their values.
- R4: Each commit drives `wr_strobe` high for exactly one system cycle. In that cycle `wr_addr` holds the written address and `cfg_bus` already shows the new value. Outside such cycles `cfg_bus` does not change.
- R5: While `frame_n` is high, activity on `ser_clk` and `ser_dat` changes no register and causes no strobe or error.
- R6: If `frame_n` rises after fewer than 16 shifted bits (including zero), no register changes and `frame_err` is high for exactly one cycle.
- R7: If `frame_n` rises after more than 16 shifted bits, no register changes and `frame_err` pulses for one cycle.
- R8: A serial clock rise that is sampled in the same system cycle as the `frame_n` rise is not shifted, so it neither adds to nor spoils the frame.
- R9: `wr_strobe` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Active-low frame select; the rising edge commits |
| ser_clk | input | 1 | Serial shift clock; bits are taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| cfg_bus | output | 56 | Four 14-bit registers; register k sits at bits 14k+13..14k |
| wr_strobe | output | 1 | One-cycle pulse on each successful commit |
| wr_addr | output | 2 | Address of the most recent commit |
| frame_err | output | 1 | One-cycle pulse when a frame of the wrong length ends |

## Verification
Two events can land in the same system cycle: a serial clock rise and the closing rise of the frame select. The bench provokes this by moving `ser_clk`, `ser_dat` and `frame_n` at the same instant after a full 16-bit frame. Both synchronisers then present the change on the same edge. The result counts as correct only if the original 16 bits commit to the right register, with a single strobe and no error pulse. A further frame that has already overrun to 17 bits must still be rejected.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
    localparam int CFG_DATA_W = 14;
    localparam int CFG_ADDR_W = 2;

    typedef enum logic [1:0] {
        EVT_NONE   = 2'd0,
        EVT_COMMIT = 2'd1,
        EVT_ERROR  = 2'd2
    } frame_evt_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int               W         = 3,
    parameter logic [W-1:0]     RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.s1 <= RESET_VAL;
            q.s2 <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import cfg_serial_pkg::*;
#(
    parameter int DATA_W = CFG_DATA_W,
    parameter int ADDR_W = CFG_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en_n_i,
    input  logic                       sclk_i,
    input  logic                       sdat_i,
    output frame_evt_e                 evt_o,
    output logic [DATA_W+ADDR_W-1:0]   word_o
);
    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int CW      = $clog2(FRAME_W + 2);
    localparam logic [CW-1:0] FULL = CW'(FRAME_W);
    localparam logic [CW-1:0] OVER = CW'(FRAME_W + 1);

    typedef struct packed {
        logic               sclk_prev;
        logic               en_prev;
        logic [FRAME_W-1:0] shreg;
        logic [CW-1:0]      cnt;
        frame_evt_e         evt;
    } shift_t;

    shift_t d, q;

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_i;
        d.en_prev   = en_n_i;
        d.evt       = EVT_NONE;
        if (en_n_i) begin
            // idle: counter parked, a fresh rise closes the frame
            d.cnt = '0;
            if (!q.en_prev) begin
                d.evt = (q.cnt == FULL) ? EVT_COMMIT : EVT_ERROR;
            end
        end else if (sclk_i && !q.sclk_prev) begin
            d.shreg = {q.shreg[FRAME_W-2:0], sdat_i};
            if (q.cnt != OVER) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.sclk_prev <= 1'b0;
            q.en_prev   <= 1'b1;
            q.shreg     <= '0;
            q.cnt       <= '0;
            q.evt       <= EVT_NONE;
        end else begin
            q <= d;
        end
    end

    assign evt_o  = q.evt;
    assign word_o = q.shreg;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_serial_pkg::*;
#(
    parameter int DATA_W = CFG_DATA_W,
    parameter int ADDR_W = CFG_ADDR_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  frame_evt_e                         evt_i,
    input  logic [DATA_W+ADDR_W-1:0]           word_i,
    output logic [(1<<ADDR_W)*DATA_W-1:0]      cfg_bus_o,
    output logic                               wr_strobe_o,
    output logic [ADDR_W-1:0]                  wr_addr_o,
    output logic                               frame_err_o
);
    localparam int FRAME_W  = DATA_W + ADDR_W;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            strobe;
        logic [ADDR_W-1:0]               addr;
        logic                            err;
    } bank_t;

    bank_t d, q;

    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] dec_data;

    assign dec_addr = word_i[ADDR_W-1:0];
    assign dec_data = word_i[FRAME_W-1:ADDR_W];

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        d.err    = 1'b0;
        case (evt_i)
            EVT_COMMIT: begin
                d.regs[dec_addr] = dec_data;
                d.strobe         = 1'b1;
                d.addr           = dec_addr;
            end
            EVT_ERROR: begin
                d.err = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        assign cfg_bus_o[i*DATA_W +: DATA_W] = q.regs[i];
    end

    assign wr_strobe_o = q.strobe;
    assign wr_addr_o   = q.addr;
    assign frame_err_o = q.err;
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_serial_pkg::*;
#(
    parameter int DATA_W = CFG_DATA_W,
    parameter int ADDR_W = CFG_ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             frame_n,
    input  logic                             ser_clk,
    input  logic                             ser_dat,
    output logic [(1<<ADDR_W)*DATA_W-1:0]    cfg_bus,
    output logic                             wr_strobe,
    output logic [ADDR_W-1:0]                wr_addr,
    output logic                             frame_err
);
    localparam int FRAME_W = DATA_W + ADDR_W;

    // bit 2 = select (idles high), bit 1 = clock, bit 0 = data
    logic [2:0]             pins_sync;
    frame_evt_e             evt;
    logic [FRAME_W-1:0]     word;

    cfg_sync #(
        .W         (3),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({frame_n, ser_clk, ser_dat}),
        .sync_o  (pins_sync)
    );

    cfg_shifter #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en_n_i (pins_sync[2]),
        .sclk_i (pins_sync[1]),
        .sdat_i (pins_sync[0]),
        .evt_o  (evt),
        .word_o (word)
    );

    cfg_regbank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .word_i      (word),
        .cfg_bus_o   (cfg_bus),
        .wr_strobe_o (wr_strobe),
        .wr_addr_o   (wr_addr),
        .frame_err_o (frame_err)
    );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
    parameter int DATA_W = 14,
    parameter int ADDR_W = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic [(1<<ADDR_W)*DATA_W-1:0]    cfg_bus,
    input logic                             wr_strobe,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic                             frame_err
);
    localparam int NUM_REGS = 1 << ADDR_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cfg_bus == '0 && !wr_strobe && !frame_err));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |-> $stable(cfg_bus));

    assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_strobe && frame_err));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_other
        assert_others_held_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_strobe && wr_addr != ADDR_W'(i)) |->
                $stable(cfg_bus[i*DATA_W +: DATA_W]));
    end
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_bus   (cfg_bus),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .frame_err (frame_err)
);

// File: tb/cfg_serial_port_bench.sv
`timescale 1ns/1ps
module cfg_serial_port_bench;
    localparam int DW = 14;
    localparam int AW = 2;
    localparam int NR = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [NR*DW-1:0] cfg_bus;
    logic wr_strobe;
    logic [AW-1:0] wr_addr;
    logic frame_err;

    int checks = 0;
    int errors = 0;
    int n_strobe = 0, n_err = 0, run_s = 0, run_e = 0, max_s = 0, max_e = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] exp_reg [NR];

    always #2 clk = ~clk;

    cfg_serial_port u_cfg_serial_port (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .cfg_bus(cfg_bus), .wr_strobe(wr_strobe),
        .wr_addr(wr_addr), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_strobe) begin
                n_strobe++; last_addr = wr_addr; run_s++;
                if (run_s > max_s) max_s = run_s;
            end else run_s = 0;
            if (frame_err) begin
                n_err++; run_e++;
                if (run_e > max_e) max_e = run_e;
            end else run_e = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        n_strobe = 0; n_err = 0; max_s = 0; max_e = 0;
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NR; i++)
            chk(req, 32'(cfg_bus[i*DW +: DW]), 32'(exp_reg[i]));
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            repeat (3) @(posedge clk);
            ser_clk = 1'b1;
            repeat (3) @(posedge clk);
            ser_clk = 1'b0;
            repeat (2) @(posedge clk);
        end
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        frame_n = 1'b0;
        repeat (3) @(posedge clk);
        shift_bits(bits, n);
        frame_n = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int i = 0; i < NR; i++) exp_reg[i] = '0;
        check_bank("R1 reset bank");
        chk("R1 strobe idle", 32'(wr_strobe), 0);
        chk("R1 err idle", 32'(frame_err), 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
        clear_mon();
        frame({16'h0, v, a}, 16);
        exp_reg[a] = v;
        check_bank("R2 R3 bank after write");
        chk("R4 strobe count", 32'(n_strobe), 1);
        chk("R4 strobe width", 32'(max_s), 1);
        chk("R4 strobe address", 32'(last_addr), 32'(a));
        chk("R9 no error on good frame", 32'(n_err), 0);
    endtask

    task automatic t_bad(input string req, input int n);
        clear_mon();
        frame(32'h5A5A_A5A5, n);
        check_bank({req, " bank held"});
        chk({req, " error count"}, 32'(n_err), 1);
        chk({req, " error width"}, 32'(max_e), 1);
        chk({req, " no strobe"}, 32'(n_strobe), 0);
    endtask

    task automatic t_idle_noise();
        clear_mon();
        for (int i = 0; i < 20; i++) begin
            ser_dat = i[0];
            repeat (3) @(posedge clk);
            ser_clk = 1'b1;
            repeat (3) @(posedge clk);
            ser_clk = 1'b0;
        end
        repeat (10) @(posedge clk);
        @(negedge clk);
        check_bank("R5 bank held while idle");
        chk("R5 no strobe", 32'(n_strobe), 0);
        chk("R5 no error", 32'(n_err), 0);
    endtask

    task automatic t_same_cycle(input logic [AW-1:0] a, input logic [DW-1:0] v);
        clear_mon();
        frame_n = 1'b0;
        repeat (3) @(posedge clk);
        shift_bits({16'h0, v, a}, 16);
        // extra clock rise and select rise change together
        ser_dat = ~a[0];
        ser_clk = 1'b1;
        frame_n = 1'b1;
        repeat (4) @(posedge clk);
        ser_clk = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        exp_reg[a] = v;
        check_bank("R8 bank after coincident edge");
        chk("R8 strobe count", 32'(n_strobe), 1);
        chk("R8 address", 32'(last_addr), 32'(a));
        chk("R8 no error", 32'(n_err), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (5) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_write(2'd0, 14'h2A5C);
        t_write(2'd1, 14'h1357);
        t_write(2'd2, 14'h3FFF);
        t_write(2'd3, 14'h0001);
        t_write(2'd2, 14'h0C0C);
        t_idle_noise();
        t_bad("R6 short", 10);
        t_bad("R6 empty", 0);
        t_bad("R7 long", 17);
        t_same_cycle(2'd1, 14'h2222);
        t_write(2'd3, 14'h1ABC);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule